// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block reorders the samples of a time-division frame. One sample arrives per clock on a single input stream; the frame holds `NSLOT` samples, and a pulse on `in_sync` marks the sample of slot 0. The output stream carries the same frame structure, delayed by exactly one frame. Output slot j carries the sample that arrived in the input slot named by map entry j. No sample carries a header: its position in the frame alone selects the link it reaches after a downstream demultiplexer.

Storage is two frame banks that alternate roles. One bank takes the current frame in arrival order while the other, holding the previous frame, is read in map order. Every sample therefore costs one write and one read per frame. Because each output slot reads independently, several output slots may name the same input slot, which gives multicast. An output slot whose map entry is marked invalid emits all zeros. The host loads the map through a shadow copy that becomes active only at a frame boundary, so no output frame ever mixes two maps.

A small state machine sequences start-up. HUNT waits for the first `in_sync`. HUNT goes to FILL on that pulse; FILL writes the first frame while the output stays idle. FILL goes to RUN at the next frame boundary. RUN never leaves. From then on a boundary occurs either when the slot counter wraps past `NSLOT-1` or when `in_sync` arrives early, which restarts the count at slot 0.

Top module: `tsi_switch`

## Requirements
- R1: After reset, and while no `in_sync` has yet been seen, `out_data` is all zeros and `out_sync` is low.
- R2: The sample taken together with `in_sync` is slot 0. Later samples take slots 1, 2, … in order, and the count returns to slot 0 after slot `NSLOT-1` without any `in_sync`.
- R3: Output slot j of frame k+1 carries the frame-k sample of input slot `src[j]`. `src[j]` is the zero-based input slot stored in map entry j. The output value appears in the clock cycle after input slot j of frame k+1 has been sampled.
- R4: Several map entries may hold the same `src`. Every such output slot then carries a copy of that one input sample.
- R5: An output slot whose map entry has its valid bit at 0 emits all zeros.
- R6: A map write (`map_we` with entry index `map_slot` and value `map_src`/`map_valid`) affects no output before the next frame boundary. A write made in the boundary cycle itself first takes effect at the boundary after that one.
- R7: `out_sync` is high for exactly one cycle, together with output slot 0, one frame after the input frame began.
- R8: An `in_sync` that arrives before the count wraps restarts the count at slot 0 and starts a new frame.
- R9: Throughout the first frame after the first `in_sync`, the output stays all zeros and `out_sync` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sync | input | 1 | Marks the slot-0 sample of an input frame |
| in_data | input | DW | Input sample |
| map_we | input | 1 | Write one entry of the shadow map |
| map_slot | input | SW | Output slot whose entry is written |
| map_src | input | SW | Input slot that the output slot reads |
| map_valid | input | 1 | 1 = connected slot, 0 = idle slot |
| out_sync | output | 1 | Marks the slot-0 sample of an output frame |
| out_data | output | DW | Output sample (zero when idle) |

## Verification
Every cycle, the assertions check that the slot counter steps by one or restarts on `in_sync`, and that the bank selector flips on each boundary and holds at all other times. They also check that the active map changes only at a boundary and takes the shadow contents there, that `out_sync` never lasts two cycles, and that no nonzero sample leaves while output is disabled. Only the bench scenarios can show the data itself: which stored sample lands in which output slot, that multicast and idle slots give the right values, that a map write made mid-frame or on the boundary cycle waits for the proper frame, and that the frame after an early resync is routed correctly.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } tsi_state_e;
endpackage

// File: rtl/tsi_slot_ctrl.sv
module tsi_slot_ctrl
    import tsi_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_sync,
    output logic [SW-1:0] cur_slot,
    output logic          boundary,
    output logic          emit,
    output logic          out_sync
);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    tsi_state_e    state_q, state_d;
    logic [SW-1:0] cnt_q;
    logic          last;
    logic          out_sync_q;

    always_comb begin
        last     = (cnt_q == LAST);
        cur_slot = (in_sync || last) ? '0 : SW'(cnt_q + 1'b1);
        boundary = in_sync || ((state_q != ST_HUNT) && last);
        emit     = (state_q == ST_RUN) || ((state_q == ST_FILL) && boundary);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (in_sync)  state_d = ST_FILL;
            ST_FILL: if (boundary) state_d = ST_RUN;
            ST_RUN:                state_d = ST_RUN;
            default:               state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= LAST;
        end else begin
            state_q <= state_d;
            if (state_q != ST_HUNT || in_sync)
                cnt_q <= cur_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_sync_q <= 1'b0;
        else        out_sync_q <= emit && boundary;
    end

    assign out_sync = out_sync_q;

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HUNT && !in_sync && !last) |=> (cnt_q == SW'($past(cnt_q) + 1'b1)));

    a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |=> (cnt_q == '0));

    a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |=> !out_sync);

    a_r1_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> !out_sync);
endmodule

// File: rtl/tsi_map.sv
module tsi_map #(
    parameter int NSLOT = 8,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wr_slot,
    input  logic [SW-1:0] wr_src,
    input  logic          wr_valid,
    input  logic          boundary,
    input  logic [SW-1:0] rd_slot,
    output logic [SW-1:0] rd_src,
    output logic          rd_valid
);
    logic [NSLOT-1:0][SW-1:0] shd_src_q, act_src_q;
    logic [NSLOT-1:0]         shd_v_q,   act_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_src_q <= '0;
            shd_v_q   <= '0;
            act_src_q <= '0;
            act_v_q   <= '0;
        end else begin
            if (boundary) begin
                act_src_q <= shd_src_q;
                act_v_q   <= shd_v_q;
            end
            if (we) begin
                shd_src_q[wr_slot] <= wr_src;
                shd_v_q[wr_slot]   <= wr_valid;
            end
        end
    end

    // On the boundary cycle the copy is not yet visible, so read the shadow.
    always_comb begin
        rd_src   = boundary ? shd_src_q[rd_slot] : act_src_q[rd_slot];
        rd_valid = boundary ? shd_v_q[rd_slot]   : act_v_q[rd_slot];
    end

    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(act_v_q) && $stable(act_src_q)));

    a_r6_copy_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> ((act_v_q == $past(shd_v_q)) && (act_src_q == $past(shd_src_q))));
endmodule

// File: rtl/tsi_frame_store.sv
module tsi_frame_store #(
    parameter int NSLOT = 8,
    parameter int SW    = 3,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic [SW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_slot,
    output logic [DW-1:0] rd_data
);
    localparam int NBANK = 2;

    logic          wbank_q;
    logic          wbank;
    logic [DW-1:0] bank_mem [NBANK][NSLOT];

    always_comb wbank = boundary ? ~wbank_q : wbank_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        wbank_q <= 1'b0;
        else if (boundary) wbank_q <= ~wbank_q;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (wbank == 1'(b))
                bank_mem[b][wr_slot] <= wr_data;
        end
    end

    // The read bank is always the one not being written.
    assign rd_data = bank_mem[~wbank][rd_slot];

    a_r3_swap_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (wbank_q != $past(wbank_q)));

    a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(wbank_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NSLOT = 8,
    parameter int DW    = 8,
    parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_sync,
    input  logic [DW-1:0] in_data,
    input  logic          map_we,
    input  logic [SW-1:0] map_slot,
    input  logic [SW-1:0] map_src,
    input  logic          map_valid,
    output logic          out_sync,
    output logic [DW-1:0] out_data
);
    logic [SW-1:0] cur_slot;
    logic          boundary;
    logic          emit;
    logic [SW-1:0] rd_src;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] out_q;

    tsi_slot_ctrl #(.NSLOT(NSLOT), .SW(SW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sync  (in_sync),
        .cur_slot (cur_slot),
        .boundary (boundary),
        .emit     (emit),
        .out_sync (out_sync)
    );

    tsi_map #(.NSLOT(NSLOT), .SW(SW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (map_we),
        .wr_slot  (map_slot),
        .wr_src   (map_src),
        .wr_valid (map_valid),
        .boundary (boundary),
        .rd_slot  (cur_slot),
        .rd_src   (rd_src),
        .rd_valid (rd_valid)
    );

    tsi_frame_store #(.NSLOT(NSLOT), .SW(SW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .wr_slot  (cur_slot),
        .wr_data  (in_data),
        .rd_slot  (rd_src),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= '0;
        else if (emit && rd_valid) out_q <= rd_data;
        else                       out_q <= '0;
    end

    assign out_data = out_q;

    a_r5_quiet_unless_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data != '0) |-> $past(emit));
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int DW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_sync = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          map_we = 1'b0;
    logic [SW-1:0] map_slot = '0;
    logic [SW-1:0] map_src = '0;
    logic          map_valid = 1'b0;
    logic          out_sync;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    // bench-side model of the requirements
    int   b_state = 0;              // 0 hunt, 1 fill, 2 run
    int   b_slot  = NS - 1;
    int   act_src [NS];
    int   shd_src [NS];
    bit   act_v   [NS];
    bit   shd_v   [NS];
    int   cur_d   [NS];
    int   prv_d   [NS];
    bit   cur_w   [NS];
    bit   prv_w   [NS];
    int   fr = 0;

    bit   pend_we = 0;
    int   pend_slot = 0;
    int   pend_src = 0;
    bit   pend_v = 0;

    tsi_switch #(.NSLOT(NS), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sync   (in_sync),
        .in_data   (in_data),
        .map_we    (map_we),
        .map_slot  (map_slot),
        .map_src   (map_src),
        .map_valid (map_valid),
        .out_sync  (out_sync),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (frame %0d)", tag, act, exp, fr);
        end
    endtask

    task automatic step(input bit s, input int d, input string tag);
        int  slot;
        bit  bnd, em, known, exp_sync;
        int  exp_d;
        string t;
        @(negedge clk);
        in_sync   = s;
        in_data   = DW'(d);
        map_we    = pend_we;
        map_slot  = SW'(pend_slot);
        map_src   = SW'(pend_src);
        map_valid = pend_v;
        slot = s ? 0 : ((b_slot == NS - 1) ? 0 : b_slot + 1);
        bnd  = s || (b_state != 0 && b_slot == NS - 1);
        if (bnd) begin
            for (int i = 0; i < NS; i++) begin
                prv_d[i] = cur_d[i]; prv_w[i] = cur_w[i]; cur_w[i] = 0;
                act_src[i] = shd_src[i]; act_v[i] = shd_v[i];
            end
        end
        em = (b_state == 2) || (b_state == 1 && bnd);
        exp_sync = em && bnd;
        known = 1;
        exp_d = 0;
        t = tag;
        if (!em) t = (b_state == 0) ? "R1" : "R9";
        else if (!act_v[slot]) t = "R5";
        else begin
            exp_d = prv_d[act_src[slot]];
            known = prv_w[act_src[slot]];
        end
        if (b_state != 0 || s) begin
            cur_d[slot] = d & ((1 << DW) - 1);
            cur_w[slot] = 1;
            b_slot = slot;
        end
        if (pend_we) begin
            shd_src[pend_slot] = pend_src;
            shd_v[pend_slot]   = pend_v;
        end
        if (b_state == 0 && s) b_state = 1;
        else if (b_state == 1 && bnd) b_state = 2;
        pend_we = 0;
        @(posedge clk);
        #1;
        if (known) check(t, out_data == DW'(exp_d), int'(out_data), exp_d);
        check("R7", out_sync == exp_sync, int'(out_sync), int'(exp_sync));
    endtask

    function automatic int sample_of(input int f, input int sl);
        return ((f * NS + sl) * 7 + 3) & 8'hFF;
    endfunction

    // wmode: 0 none, 1 multicast map, 2 broadcast warg, 3 all idle, 4 permutation map
    task automatic run_frame(input bit sync0, input int len, input string tag,
                             input int wmode, input int warg);
        for (int j = 0; j < len; j++) begin
            if (wmode != 0) begin
                pend_we = 1; pend_slot = j; pend_v = 1;
                case (wmode)
                    1: begin pend_src = j / 2; pend_v = (j < 6); end
                    2: pend_src = warg;
                    3: begin pend_src = 0; pend_v = 0; end
                    default: pend_src = (3 * j + 1) % NS;
                endcase
            end
            step(sync0 && j == 0, sample_of(fr, j), tag);
        end
        fr++;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            act_src[i] = 0; shd_src[i] = 0; act_v[i] = 0; shd_v[i] = 0;
            cur_d[i] = 0; prv_d[i] = 0; cur_w[i] = 0; prv_w[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1", out_data == '0, int'(out_data), 0);
        check("R1", out_sync == 1'b0, int'(out_sync), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: load permutation map while still hunting for sync
        run_frame(0, NS, "R1", 4, 0);
        fr = 0;
        // R9: first frame after sync stays idle
        run_frame(1, NS, "R9", 0, 0);
        // R3 / R2: permuted output, counter wraps without sync
        run_frame(0, NS, "R3", 0, 0);
        run_frame(0, NS, "R2", 0, 0);
        // R6: multicast map written during this frame, incl. boundary cycle
        run_frame(0, NS, "R6", 1, 0);
        // R4: multicast now active (slots 6,7 idle -> R5)
        run_frame(0, NS, "R4", 0, 0);
        run_frame(1, NS, "R4", 4, 0);
        // R8: short frame, early resync
        run_frame(1, 5, "R8", 0, 0);
        run_frame(1, NS, "R8", 0, 0);
        run_frame(0, NS, "R8", 0, 0);
        // R4: broadcast sweep over every input slot
        for (int s = 0; s < NS; s++) run_frame(0, NS, "R4", 2, s);
        run_frame(0, NS, "R4", 3, 0);
        // R5: all output slots idle
        run_frame(0, NS, "R5", 0, 0);
        run_frame(0, NS, "R5", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule